// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block walks a framebuffer in memory, one display line after another, and turns each line into a series of burst read requests. Software programs five values: the byte address of the first pixel, the number of bytes to fetch per line, the byte distance between the starts of adjacent lines, the number of lines minus one, and the bus options. The bus options are the burst size in beats and a cap on how many reads may be in flight at once. Because the per-line byte count and the line stride are separate values, each line in memory may be padded.

A one-cycle `frame_start` pulse, given while the generator is idle, captures the whole configuration and starts a new frame from the base address. After that, the configuration inputs may change freely without disturbing the frame in progress. Requests leave on a valid/ready channel. Once `req_valid` is high, it stays high and `req_addr` and `req_bytes` hold their values until the cycle in which `req_ready` is sampled high. That cycle is the handshake. A request counts as outstanding from its handshake until a `cpl_valid` pulse returns it. The channel is throttled only by the outstanding cap, never by `req_ready`.

Top module: `fbs_scan_top`

## Requirements
- R1: After reset, `req_valid` and `busy` are 0 and `outstanding` is 0.
- R2: A `frame_start` pulse while `busy` is 0 sets `busy` in the next cycle, and the first request then carries `cfg_base` as its address.
- R3: The burst field value n (1 to 15) means n beats, and the value 0 means 16 beats. A beat is BEAT_BYTES (8) bytes. Each request asks for the smaller of one full burst and the bytes still left in the current line, so only the last burst of a line can be short.
- R4: The requests within a line cover consecutive addresses. Line k starts at base + k × pitch.
- R5: Exactly `cfg_lines_m1`+1 lines are fetched. In the cycle after the handshake of the last request of the last line, `busy` and `req_valid` are 0.
- R6: While `busy` is 1, `req_valid` is 1 exactly when `outstanding` is below the limit. The limit is the `cfg_max_outst` field, and a field value of 0 means 2^OW (8).
- R7: Each `cpl_valid` cycle lowers `outstanding` by one. A `cpl_valid` pulse while `outstanding` is 0 is ignored.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 in the next cycle and `req_addr` and `req_bytes` do not change.
- R9: While `busy` is 1, changes on the configuration inputs and further `frame_start` pulses have no effect on the requests issued.
- R10: A handshake and a completion in the same cycle leave `outstanding` unchanged. Otherwise `outstanding` tracks handshakes minus accepted completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Frame start pulse, honoured only when idle |
| cfg_base | input | AW (32) | Byte address of the first pixel |
| cfg_line_bytes | input | LW (16) | Bytes fetched per line (nonzero) |
| cfg_pitch | input | LW (16) | Byte step between line starts |
| cfg_lines_m1 | input | CW (12) | Line count minus one |
| cfg_burst_beats | input | 4 | Burst length in beats, 0 means 16 |
| cfg_max_outst | input | OW (3) | Outstanding request cap, 0 means 2^OW |
| req_valid | output | 1 | Request presented |
| req_ready | input | 1 | Request accepted this cycle |
| req_addr | output | AW (32) | Byte address of the request |
| req_bytes | output | BW (8) | Byte count of the request |
| cpl_valid | input | 1 | One outstanding request finished |
| busy | output | 1 | A frame is being walked |
| outstanding | output | OW+1 (4) | Requests in flight |

## Verification
The assertions check the rules that hold cycle by cycle. A stalled request stays stable. The in-flight count never exceeds the captured limit and falls by one on each completion. A request is never larger than one burst. The first address of a frame equals the captured base. Only the bench scenarios can show that a whole frame has the right shape: the burst split at each line end, the pitch stride from line to line, the total line count and the moment `busy` falls. The bench sweeps line length, burst size, line count and limit against arithmetic expectations, and it changes the inputs mid-frame to show they are ignored.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;

  // 4-bit burst field: 0 encodes the largest burst of 16 beats.
  function automatic logic [4:0] beats_decode(input logic [3:0] field);
    return (field == 4'd0) ? 5'd16 : {1'b0, field};
  endfunction

endpackage

// File: rtl/fbs_cfg_latch.sv
module fbs_cfg_latch #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 12,
  parameter int OW         = 3,
  parameter int BEAT_BYTES = 8,
  localparam int BW        = $clog2(16 * BEAT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [LW-1:0] in_line_bytes,
  input  logic [LW-1:0] in_pitch,
  input  logic [CW-1:0] in_lines_m1,
  input  logic [3:0]    in_burst_beats,
  input  logic [OW-1:0] in_max_outst,
  output logic [LW-1:0] hold_line_bytes,
  output logic [LW-1:0] hold_pitch,
  output logic [CW-1:0] hold_lines_m1,
  output logic [BW-1:0] hold_burst_bytes,
  output logic [OW:0]   hold_limit
);
  import fbs_pkg::*;

  logic [BW-1:0] burst_calc;
  logic [OW:0]   limit_calc;

  always_comb begin
    burst_calc = BW'(beats_decode(in_burst_beats)) * BW'(BEAT_BYTES);
    if (in_max_outst == '0) limit_calc = {1'b1, {OW{1'b0}}};
    else                    limit_calc = {1'b0, in_max_outst};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_line_bytes  <= '0;
      hold_pitch       <= '0;
      hold_lines_m1    <= '0;
      hold_burst_bytes <= '0;
      hold_limit       <= '0;
    end else if (load) begin
      hold_line_bytes  <= in_line_bytes;
      hold_pitch       <= in_pitch;
      hold_lines_m1    <= in_lines_m1;
      hold_burst_bytes <= burst_calc;
      hold_limit       <= limit_calc;
    end
  end

  // R9: captured values only move on a load
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_line_bytes) && $stable(hold_pitch) &&
              $stable(hold_lines_m1) && $stable(hold_burst_bytes) && $stable(hold_limit));

endmodule

// File: rtl/fbs_line_walker.sv
module fbs_line_walker #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 12,
  parameter int BEAT_BYTES = 8,
  localparam int BW        = $clog2(16 * BEAT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic [LW-1:0] line_bytes,
  input  logic [LW-1:0] pitch,
  input  logic [CW-1:0] lines_m1,
  input  logic [BW-1:0] burst_bytes,
  input  logic          accept,
  output logic          active,
  output logic [AW-1:0] cur_addr,
  output logic [BW-1:0] cur_bytes
);
  import fbs_pkg::*;

  walk_state_e   state_q;
  logic [AW-1:0] line_addr_q;
  logic [LW-1:0] offs_q;
  logic [CW-1:0] line_idx_q;
  logic [LW-1:0] remain;
  logic          last_in_line;
  logic          last_line;

  always_comb begin
    remain       = line_bytes - offs_q;
    last_in_line = (remain <= LW'(burst_bytes));
    last_line    = (line_idx_q == lines_m1);
    cur_bytes    = last_in_line ? BW'(remain) : burst_bytes;
    cur_addr     = line_addr_q + AW'(offs_q);
    active       = (state_q == WALK_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WALK_IDLE;
      line_addr_q <= '0;
      offs_q      <= '0;
      line_idx_q  <= '0;
    end else if (state_q == WALK_IDLE) begin
      if (start) begin
        state_q     <= WALK_RUN;
        line_addr_q <= start_base;
        offs_q      <= '0;
        line_idx_q  <= '0;
      end
    end else if (accept) begin
      if (!last_in_line) begin
        offs_q <= offs_q + LW'(burst_bytes);
      end else if (last_line) begin
        state_q <= WALK_IDLE;
      end else begin
        line_addr_q <= line_addr_q + AW'(pitch);
        line_idx_q  <= line_idx_q + 1'b1;
        offs_q      <= '0;
      end
    end
  end

  // R3: a request never exceeds one burst
  a_r3_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cur_bytes <= burst_bytes);

endmodule

// File: rtl/fbs_credit.sv
module fbs_credit #(
  parameter int OW = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic        give_back,
  input  logic [OW:0] limit,
  output logic [OW:0] count,
  output logic        room
);
  logic dec;

  always_comb begin
    dec  = give_back && (count != '0);
    room = (count < limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             count <= '0;
    else if (take && !dec)  count <= count + 1'b1;
    else if (dec && !take)  count <= count - 1'b1;
  end

  // R7: a completion with nothing new issued lowers the count by one
  a_r7_cpl_dec: assert property (@(posedge clk) disable iff (!rst_n)
    give_back && !take && count != '0 |=> count == $past(count) - 1'b1);

  // R10: simultaneous issue and completion keeps the count
  a_r10_net_zero: assert property (@(posedge clk) disable iff (!rst_n)
    give_back && take && count != '0 |=> $stable(count));

endmodule

// File: rtl/fbs_scan_top.sv
module fbs_scan_top #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int CW         = 12,
  parameter int OW         = 3,
  parameter int BEAT_BYTES = 8,
  localparam int BW        = $clog2(16 * BEAT_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start,
  input  logic [AW-1:0] cfg_base,
  input  logic [LW-1:0] cfg_line_bytes,
  input  logic [LW-1:0] cfg_pitch,
  input  logic [CW-1:0] cfg_lines_m1,
  input  logic [3:0]    cfg_burst_beats,
  input  logic [OW-1:0] cfg_max_outst,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [BW-1:0] req_bytes,
  input  logic          cpl_valid,
  output logic          busy,
  output logic [OW:0]   outstanding
);
  logic          load;
  logic          accept;
  logic          room;
  logic [LW-1:0] h_line_bytes;
  logic [LW-1:0] h_pitch;
  logic [CW-1:0] h_lines_m1;
  logic [BW-1:0] h_burst_bytes;
  logic [OW:0]   h_limit;

  always_comb begin
    load      = frame_start && !busy;
    req_valid = busy && room;
    accept    = req_valid && req_ready;
  end

  fbs_cfg_latch #(.AW(AW), .LW(LW), .CW(CW), .OW(OW), .BEAT_BYTES(BEAT_BYTES)) cfg_i (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_line_bytes(cfg_line_bytes), .in_pitch(cfg_pitch), .in_lines_m1(cfg_lines_m1),
    .in_burst_beats(cfg_burst_beats), .in_max_outst(cfg_max_outst),
    .hold_line_bytes(h_line_bytes), .hold_pitch(h_pitch), .hold_lines_m1(h_lines_m1),
    .hold_burst_bytes(h_burst_bytes), .hold_limit(h_limit)
  );

  fbs_line_walker #(.AW(AW), .LW(LW), .CW(CW), .BEAT_BYTES(BEAT_BYTES)) walk_i (
    .clk(clk), .rst_n(rst_n), .start(load), .start_base(cfg_base),
    .line_bytes(h_line_bytes), .pitch(h_pitch), .lines_m1(h_lines_m1),
    .burst_bytes(h_burst_bytes), .accept(accept),
    .active(busy), .cur_addr(req_addr), .cur_bytes(req_bytes)
  );

  fbs_credit #(.OW(OW)) credit_i (
    .clk(clk), .rst_n(rst_n), .take(accept), .give_back(cpl_valid),
    .limit(h_limit), .count(outstanding), .room(room)
  );

  // R8: a stalled request holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_bytes));

  // R6: the in-flight count never passes the captured limit
  a_r6_limit: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> outstanding <= h_limit);

  // R2: a new frame opens at the base presented with the start pulse
  a_r2_first_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> req_addr == $past(cfg_base));

  // R5: no request while idle
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

endmodule

// File: tb/fbs_scan_top_tb_top.sv
module fbs_scan_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_line_bytes = '0;
  logic [15:0] cfg_pitch = '0;
  logic [11:0] cfg_lines_m1 = '0;
  logic [3:0]  cfg_burst_beats = '0;
  logic [2:0]  cfg_max_outst = '0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_addr;
  logic [7:0]  req_bytes;
  logic        cpl_valid = 1'b0;
  logic        busy;
  logic [3:0]  outstanding;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  fbs_scan_top dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_base(cfg_base), .cfg_line_bytes(cfg_line_bytes), .cfg_pitch(cfg_pitch),
    .cfg_lines_m1(cfg_lines_m1), .cfg_burst_beats(cfg_burst_beats),
    .cfg_max_outst(cfg_max_outst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_bytes(req_bytes), .cpl_valid(cpl_valid),
    .busy(busy), .outstanding(outstanding)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic run_frame(input int unsigned base, input int len, input int pitch,
                           input int lm1, input int beats, input int mo, input bit poke);
    int bb, lim, line, offs, pending, exp_bytes, guard;
    bit done, poked, held;
    longint h_addr, h_bytes;
    bb  = ((beats == 0) ? 16 : beats) * 8;
    lim = (mo == 0) ? 8 : mo;
    @(negedge clk);
    cfg_base = base; cfg_line_bytes = 16'(len); cfg_pitch = 16'(pitch);
    cfg_lines_m1 = 12'(lm1); cfg_burst_beats = 4'(beats); cfg_max_outst = 3'(mo);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    // R9: scramble the inputs once the frame is running
    cfg_base = base ^ 32'h5A5A_0000; cfg_line_bytes = 16'(len + 37);
    cfg_pitch = 16'(pitch + 512); cfg_lines_m1 = 12'(lm1 + 5);
    cfg_burst_beats = 4'(beats + 3); cfg_max_outst = 3'(mo + 1);
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    chk(req_addr === base, "R2 first address", req_addr, base);
    line = 0; offs = 0; pending = 0; done = 0; poked = 0; held = 0; guard = 0;
    while (!done && guard < 5000) begin
      guard++;
      req_ready = lfsr[0] | lfsr[3];
      cpl_valid = lfsr[1] && (pending > 0);
      step_lfsr();
      #1;
      chk(outstanding == 4'(pending), "R10 outstanding count", outstanding, pending);
      if (held) begin
        chk(req_valid && req_addr == h_addr && req_bytes == h_bytes,
            "R8 stalled request held", req_addr, h_addr);
        held = 0;
      end
      if (req_valid) chk(pending < lim, "R6 valid below limit", pending, lim);
      else chk(!busy || pending >= lim, "R6 valid when room", pending, lim);
      if (req_valid && !req_ready) begin
        held = 1; h_addr = req_addr; h_bytes = req_bytes;
      end
      if (req_valid && req_ready) begin
        exp_bytes = (len - offs < bb) ? (len - offs) : bb;
        chk(req_addr == 32'(base + line * pitch + offs), "R4 request address",
            req_addr, 32'(base + line * pitch + offs));
        chk(req_bytes == 8'(exp_bytes), "R3 request size", req_bytes, exp_bytes);
        if (offs + exp_bytes >= len) begin
          if (line == lm1) done = 1;
          else begin line++; offs = 0; end
        end else offs += exp_bytes;
        pending++;
        if (poke && !poked && !done) begin
          frame_start = 1'b1;  // R9: ignored while busy
          poked = 1;
        end
      end
      if (cpl_valid) pending--;
      @(negedge clk);
      frame_start = 1'b0;
    end
    req_ready = 1'b0; cpl_valid = 1'b0;
    #1;
    chk(done, "R5 frame completes", done, 1);
    chk(!busy && !req_valid, "R5 idle after last line", busy, 0);
    while (pending > 0) begin
      cpl_valid = 1'b1;
      @(negedge clk);
      pending--;
      cpl_valid = 1'b0;
      #1;
      chk(outstanding == 4'(pending), "R7 completion drains", outstanding, pending);
    end
    cpl_valid = 1'b1;  // R7: extra completion at zero
    @(negedge clk);
    cpl_valid = 1'b0;
    #1;
    chk(outstanding == 4'd0, "R7 completion at zero ignored", outstanding, 0);
  endtask

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lens[5]  = '{1, 8, 100, 128, 129};
    int lms[3]   = '{0, 1, 3};
    int bts[4]   = '{0, 1, 3, 16 - 1};
    int mos[3]   = '{0, 1, 2};
    int n;
    repeat (3) @(negedge clk);
    #1;
    chk(!req_valid && !busy && outstanding == 0, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    n = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 5; b++)
        for (int d = 0; d < 4; d++)
          for (int e = 0; e < 3; e++) begin
            run_frame(32'h1000_0000 + 32'(n * 4096), lens[b], lens[b] + (n % 3) * 24,
                      lms[a], bts[d], mos[e], (n % 2) == 1);
            n++;
          end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule